// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Image Reader

This block reads a configuration image out of a three-wire serial EEPROM that stores 16-bit words behind a 6-bit word address. It is started with a one-cycle pulse on `start_i`. It then walks the word addresses upward from zero and sends a separate read command for each word. After each command it checks the dummy bit the memory returns, then shifts in the 16 data bits. Each word is presented on a one-cycle output strobe along with its address.

While the words stream out, the block keeps a 16-bit wrap-around sum of them. When the last word has been read, it reports whether that sum hit the fixed target value, which means the image is valid. If the memory answered a command with a bad dummy bit, the block abandons the read at once and raises a protocol error instead. The serial clock idles low, and every clock level is held for `HOLD_CYC` system clocks.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Each word is fetched by a 9-bit command sent MSB first: bits 1, 1, 0 and then the 6-bit word address (0x180 OR address). Commands go to addresses 0, 1, ... N_WORDS-1 in ascending order, one command per word.
- R2: Chip select is high for every command bit and data bit. Each command bit is placed on `mw_di_o` while `mw_sk_o` is low and does not change while `mw_sk_o` is high.
- R3: After the 9th command pulse, `mw_do_i` is sampled as the dummy bit. A 1 there ends the run at once: chip select drops, no further words are delivered, `proto_err_o` becomes 1 and `image_ok_o` becomes 0.
- R4: A word is 16 bits, MSB first, each sampled after its own clock pulse. It appears on `word_data_o` with `word_addr_o` during a single-cycle `word_valid_o` pulse.
- R5: After each word, chip select goes low and exactly one serial clock pulse is issued with chip select low before the next command starts.
- R6: At the end of a complete run, `image_ok_o` is 1 exactly when the 16-bit modular sum of all N_WORDS words equals 0x1234, the sum wrapping past 0xFFFF.
- R7: `image_ok_o` and `proto_err_o` keep their previous values for the whole run and change only at its end, which `done_o` marks with a single-cycle pulse.
- R8: The error flag dominates: whenever `proto_err_o` is 1, `image_ok_o` is 0.
- R9: Each serial clock high phase lasts exactly HOLD_CYC system clocks, and each low phase inside a word transfer lasts at least HOLD_CYC clocks.
- R10: A `start_i` pulse while `busy_o` is high has no effect on the running transfer.
- R11: After reset and whenever idle, `mw_cs_o`, `mw_sk_o` and `mw_di_o` are low. After reset, `image_ok_o`, `proto_err_o`, `done_o` and `word_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin reading the image |
| mw_cs_o | output | 1 | EEPROM chip select |
| mw_sk_o | output | 1 | EEPROM serial clock, idles low |
| mw_di_o | output | 1 | Serial data into the EEPROM |
| mw_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | A run is in progress |
| word_valid_o | output | 1 | One-cycle strobe for a captured word |
| word_addr_o | output | ADDR_W | Address of the strobed word |
| word_data_o | output | WORD_W | Captured word |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| image_ok_o | output | 1 | Last completed run summed to the target |
| proto_err_o | output | 1 | Last run was aborted by a bad dummy bit |

## Verification
The bench pits the reader against an EEPROM model that records every command. The model can force the dummy bit high at word 0, at a middle word or at the last word. A reader that ignored the dummy bit would keep streaming words and could still report a valid image. One that checked it at the wrong time would abort good runs.

Several images are checked against the target:
- one image lands exactly on 0x1234;
- one misses it by one;
- one, made almost entirely of 0xFFFF words, reaches the target only through wrap-around.

A reader with a wide or saturating sum would then judge the image wrongly.

The bench also:
- counts the clock pulses between chip-select windows, which exposes a missing or doubled stop pulse;
- measures the width of every high phase;
- fires a second start in the middle of a run, which would restart the address walk if it were not ignored.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_STOP} mw_state_e;
  localparam logic [2:0] MW_READ_HDR = 3'b110;  // start bit + read opcode
endpackage

// File: rtl/mw_rd_timer.sv
module mw_rd_timer #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_rd_csum.sv
module mw_rd_csum #(
  parameter int          WORD_W = 16,
  parameter logic [15:0] TARGET = 16'h1234
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              match_o
);
  logic [WORD_W-1:0] acc_q;

  assign match_o = (acc_q == WORD_W'(TARGET));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= acc_q + word_i;  // modular wrap intended
  end
endmodule

// File: rtl/mw_rd_seq.sv
module mw_rd_seq
  import mw_rd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              run_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              fin_ok_o,
  output logic              fin_err_o
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int MAX_W = (CMD_W > WORD_W) ? CMD_W : WORD_W;
  localparam int BIT_W = $clog2(MAX_W);
  localparam logic [BIT_W-1:0]  CMD_LAST  = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0]  WORD_LAST = BIT_W'(WORD_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(N_WORDS - 1);

  mw_state_e         state_q;
  logic              ph_q;      // serial clock level
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] sh_q;
  logic              slot_end;  // falling edge of the serial clock

  assign slot_end = tick_i && ph_q;
  assign run_o    = (state_q != ST_IDLE);
  assign cs_o     = (state_q == ST_CMD) || (state_q == ST_DATA);
  assign sk_o     = ph_q;
  assign di_o     = (state_q == ST_CMD) && cmd_q[CMD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ph_q         <= 1'b0;
      bit_q        <= '0;
      addr_q       <= '0;
      cmd_q        <= '0;
      sh_q         <= '0;
      word_valid_o <= 1'b0;
      word_addr_o  <= '0;
      word_data_o  <= '0;
      fin_ok_o     <= 1'b0;
      fin_err_o    <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      fin_ok_o     <= 1'b0;
      fin_err_o    <= 1'b0;
      if (tick_i && !ph_q) ph_q <= 1'b1;
      if (slot_end)        ph_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          ph_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_CMD;
            addr_q  <= '0;
            bit_q   <= '0;
            cmd_q   <= {MW_READ_HDR, {ADDR_W{1'b0}}};
          end
        end
        ST_CMD: if (slot_end) begin
          cmd_q <= cmd_q << 1;
          if (bit_q == CMD_LAST) begin
            bit_q <= '0;
            if (do_i) begin
              state_q   <= ST_IDLE;   // bad dummy bit: abort
              fin_err_o <= 1'b1;
            end else begin
              state_q <= ST_DATA;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_DATA: if (slot_end) begin
          sh_q <= {sh_q[WORD_W-2:0], do_i};
          if (bit_q == WORD_LAST) begin
            bit_q        <= '0;
            state_q      <= ST_STOP;
            word_valid_o <= 1'b1;
            word_addr_o  <= addr_q;
            word_data_o  <= {sh_q[WORD_W-2:0], do_i};
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_STOP: if (slot_end) begin
          if (addr_q == ADDR_LAST) begin
            state_q  <= ST_IDLE;
            fin_ok_o <= 1'b1;
          end else begin
            addr_q  <= addr_q + 1'b1;
            cmd_q   <= {MW_READ_HDR, addr_q + 1'b1};
            state_q <= ST_CMD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int          HOLD_CYC = 100,
  parameter int          ADDR_W   = 6,
  parameter int          WORD_W   = 16,
  parameter int          N_WORDS  = 64,
  parameter logic [15:0] TARGET   = 16'h1234
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mw_cs_o,
  output logic              mw_sk_o,
  output logic              mw_di_o,
  input  logic              mw_do_i,
  output logic              busy_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              done_o,
  output logic              image_ok_o,
  output logic              proto_err_o
);
  logic tick, run, fin_ok, fin_err, sum_match;

  mw_rd_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick)
  );

  mw_rd_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_seq (
    .clk_i, .rst_ni, .start_i, .tick_i(tick), .do_i(mw_do_i),
    .run_o(run), .cs_o(mw_cs_o), .sk_o(mw_sk_o), .di_o(mw_di_o),
    .word_valid_o, .word_addr_o, .word_data_o,
    .fin_ok_o(fin_ok), .fin_err_o(fin_err)
  );

  mw_rd_csum #(.WORD_W(WORD_W), .TARGET(TARGET)) u_csum (
    .clk_i, .rst_ni, .clr_i(start_i && !run), .add_i(word_valid_o),
    .word_i(word_data_o), .match_o(sum_match)
  );

  assign busy_o = run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      image_ok_o  <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      done_o <= fin_ok || fin_err;
      if (fin_err) begin
        image_ok_o  <= 1'b0;
        proto_err_o <= 1'b1;
      end else if (fin_ok) begin
        image_ok_o  <= sum_match;
        proto_err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HOLD_CYC = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic mw_cs_o,
  input logic mw_sk_o,
  input logic mw_di_o,
  input logic word_valid_o,
  input logic done_o,
  input logic image_ok_o,
  input logic proto_err_o
);
  logic [15:0] hi_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_len_q <= '0;
    else if (!mw_sk_o)          hi_len_q <= '0;
    else if (hi_len_q != 16'hFFFF) hi_len_q <= hi_len_q + 1'b1;
  end

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mw_cs_o && !mw_sk_o && !mw_di_o));

  a_r2_di_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_sk_o && $past(mw_sk_o)) |-> $stable(mw_di_o));

  a_r8_err_over_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !image_ok_o);

  a_r4_word_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (busy_o && !mw_cs_o));

  a_r9_high_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mw_sk_o) |-> (hi_len_q == 16'(HOLD_CYC)));

  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(image_ok_o) && $stable(proto_err_o)));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i, .rst_ni, .busy_o, .mw_cs_o, .mw_sk_o, .mw_di_o,
  .word_valid_o, .done_o, .image_ok_o, .proto_err_o
);

// File: tb/mw_eeprom_reader_test.sv
module mw_eeprom_reader_test;
  localparam int HOLD = 3;
  localparam int NW   = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, do_r = 1'b1;
  logic cs, sk, di, busy, wvalid, done, ok, perr;
  logic [5:0]  waddr;
  logic [15:0] wdata;

  always #10 clk = ~clk;

  mw_eeprom_reader #(.HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mw_cs_o(cs), .mw_sk_o(sk), .mw_di_o(di), .mw_do_i(do_r),
    .busy_o(busy), .word_valid_o(wvalid), .word_addr_o(waddr),
    .word_data_o(wdata), .done_o(done), .image_ok_o(ok), .proto_err_o(perr)
  );

  int errors = 0, checks = 0;
  logic [15:0] img [NW];
  int err_word = -1;
  int bitcnt = 0, cur_addr = 0, cmd_cnt = 0, stop_cnt = 0;
  int cmd_bad = 0, stop_bad = 0, word_cnt = 0, word_bad = 0;
  int hold_bad = 0, di_bad = 0, hi_len = 0;
  logic [8:0] cmd_sh = '0;
  logic prev_sk = 1'b0, prev_di = 1'b0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] img_sum();
    logic [15:0] s = '0;
    for (int i = 0; i < NW; i++) s = s + img[i];
    return s;
  endfunction

  // EEPROM model
  always @(posedge sk or negedge cs) begin
    if (sk) begin
      if (!cs) stop_cnt++;
      else if (bitcnt < 9) begin
        if (bitcnt == 0 && cmd_cnt > 0) begin
          if (stop_cnt != 1) stop_bad++;   // R5
          stop_cnt = 0;
        end
        cmd_sh = {cmd_sh[7:0], di};
        bitcnt++;
        if (bitcnt == 9) begin
          if (cmd_sh != (9'h180 | 9'(cmd_cnt))) cmd_bad++;  // R1
          cur_addr = int'(cmd_sh[5:0]);
          cmd_cnt++;
          do_r = (cur_addr == err_word);
        end
      end else if (bitcnt < 25) begin
        do_r = img[cur_addr][24 - bitcnt];
        bitcnt++;
      end
    end else begin
      bitcnt = 0;
      do_r = 1'b1;
    end
  end

  // Output and timing monitor
  always @(negedge clk) begin
    if (wvalid) begin
      if (waddr != 6'(word_cnt) || wdata != img[word_cnt]) word_bad++;
      word_cnt++;
    end
    if (sk && prev_sk && di != prev_di) di_bad++;
    if (sk) hi_len++;
    if (!sk && prev_sk) begin
      if (hi_len != HOLD) hold_bad++;
      hi_len = 0;
    end
    prev_sk = sk;
    prev_di = di;
  end

  task automatic run_image(input int ew, input bit mid_start, output bit timed_out);
    bit prev_ok, prev_err;
    int cyc = 0;
    err_word = ew;
    cmd_cnt = 0; stop_cnt = 0; cmd_bad = 0; stop_bad = 0;
    word_cnt = 0; word_bad = 0;
    prev_ok = ok; prev_err = perr;
    timed_out = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R4 busy after start", busy, 1);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 2000) begin
        start = 1'b1;
        @(negedge clk); start = 1'b0; cyc++;
        chk(ok == prev_ok && perr == prev_err, "R7 flags held mid-run",
            {ok, perr}, {prev_ok, prev_err});
      end
      if (cyc > 30000) begin timed_out = 1'b1; break; end
    end
    chk(!timed_out, "watchdog", cyc, 30000);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  task automatic check_good(input string tag);
    logic [15:0] s = img_sum();
    chk(cmd_cnt == NW && cmd_bad == 0, "R1 command framing", cmd_bad, 0);
    chk(word_cnt == NW && word_bad == 0, "R4 word stream", word_cnt, NW);
    chk(stop_bad == 0 && stop_cnt == 1, "R5 one stop pulse", stop_bad, 0);
    chk(ok == (s == 16'h1234), {"R6 checksum ", tag}, ok, (s == 16'h1234));
    chk(perr == 1'b0, "R3 no error on clean run", perr, 0);
    chk(di_bad == 0, "R2 di stable while sk high", di_bad, 0);
    chk(hold_bad == 0, "R9 high phase width", hold_bad, 0);
  endtask

  task automatic check_err(input int ew);
    chk(perr == 1'b1, "R3 error flagged", perr, 1);
    chk(ok == 1'b0, "R8 error forces invalid", ok, 0);
    chk(word_cnt == ew, "R3 words before abort", word_cnt, ew);
    chk(cs == 1'b0 && busy == 1'b0, "R3 cs dropped after abort", cs, 0);
  endtask

  initial begin
    bit to;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!cs && !sk && !di, "R11 lines low in reset", {cs, sk, di}, 0);
    chk(!ok && !perr && !done && !wvalid, "R11 flags clear in reset",
        {ok, perr, done, wvalid}, 0);
    rst_n = 1'b1;
    repeat (HOLD * 4) @(negedge clk);
    chk(!cs && !sk && !di && !busy, "R11 idle lines low", {cs, sk, di, busy}, 0);

    // random image hitting the target exactly
    for (int i = 0; i < NW; i++) img[i] = 16'($urandom);
    img[NW-1] = '0; img[NW-1] = 16'h1234 - img_sum();
    run_image(-1, 1'b1, to);   // R10: stray start mid-run
    check_good("exact hit");
    chk(ok == 1'b1, "R6 valid image", ok, 1);

    // random image off by one, start again mid-run (R7 prev ok = 1)
    for (int i = 0; i < NW; i++) img[i] = 16'($urandom);
    img[NW-1] = '0; img[NW-1] = 16'h1235 - img_sum();
    run_image(-1, 1'b1, to);
    check_good("miss by one");
    chk(ok == 1'b0, "R6 invalid image", ok, 0);

    // wrap-around: mostly 0xFFFF
    for (int i = 0; i < NW; i++) img[i] = 16'hFFFF;
    img[NW-1] = '0; img[NW-1] = 16'h1234 - img_sum();
    run_image(-1, 1'b0, to);
    check_good("wrap");
    chk(ok == 1'b1, "R6 wrapped sum valid", ok, 1);

    // dummy-bit errors at first, middle and last word
    run_image(0, 1'b0, to);
    check_err(0);
    run_image(37, 1'b0, to);
    check_err(37);
    run_image(NW - 1, 1'b0, to);
    check_err(NW - 1);

    // clean run clears the error flag
    for (int i = 0; i < NW; i++) img[i] = (i % 2) ? 16'hAAAA : 16'h5555;
    img[NW-1] = '0; img[NW-1] = 16'h1234 - img_sum();
    run_image(-1, 1'b0, to);
    check_good("pattern");
    chk(ok == 1'b1 && perr == 1'b0, "R8 recovery after error", {ok, perr}, 2);

    repeat (HOLD * 4) @(negedge clk);
    chk(!cs && !sk && !di, "R11 idle after run", {cs, sk, di}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule